// File: doc/BRIEF.md
# Configurable Logic Cell

A small programmable logic block that builds one output bit from a pool of 32 source signals. Four selectors each pick one source as a data line. Four gates each OR any chosen mix of the data lines, taken in true or inverted form, and can invert their own result. The four gate results then feed a function core that runs one of eight modes: four pure gate networks and four storage elements (set-reset latch, edge-clocked D with set and reset, transparent D with set and reset, and edge-clocked J-K with reset).

The result passes through an output invert bit and a cell enable. It drives two identical outputs, one for internal consumers and one for a pin. Software sets the cell up through a small write-only register interface. Clocked storage runs in the block's own clock domain. A gate-derived clock is turned into a one-cycle edge event, so the whole cell stays synchronous.

Top module: `logic_cell`

## Requirements
- R1: A write takes place on a rising clock edge while `cfg_we` is high, and it acts from the next cycle on. At `cfg_addr` 0 the control word holds: bit 0 enable, bit 1 output invert, bits 4:2 mode, and bits 11:8 the invert bits for gates 1 to 4. At address 1, the select of line k sits in bits 8k+4:8k. At address 2, the mask of gate k is byte k: bit j picks line j in true form and bit 4+j picks line j inverted. A write to address 3 changes nothing.
- R2: Data line k equals `src_in[select k]` for any select value from 0 to 31.
- R3: Gate k is the OR of its masked terms, XORed with its invert bit. A gate with an empty mask is 0 before inversion.
- R4: The combinational modes are 0 (g1&g2)|(g3&g4), 1 (g1|g2)^(g3|g4), 2 g1&g2&g3&g4 and 7 the NAND of all four gates. Their output follows the inputs in the same cycle.
- R5: The output invert bit complements the core result. This gives AND-OR-INVERT from mode 0 and OR-XNOR from mode 1.
- R6: Mode 3 is a set-reset latch with set = g1|g2 and reset = g3|g4. Reset wins, and the output shows the new state after the next rising clock edge.
- R7: Mode 4 is a clocked D element. An edge is a cycle in which g1 is high after a cycle in which it was low. D is g2, g4 sets and g3 resets, with reset first. Set and reset act without an edge.
- R8: Mode 6 is a transparent D latch. It is open while g3 is high, D is g2, g4 sets and g1 resets, with reset first.
- R9: Mode 5 is a J-K element. It is clocked by g1 edges as in R7, with J = g2, K = g4 and g3 as a reset that needs no edge. J and K together toggle the state.
- R10: While the cell is disabled both outputs are 0. After any edge taken while the cell is disabled or in a combinational mode, the storage state is 0.
- R11: The pin output always equals the internal output.
- R12: After reset, every configuration field and the storage state are 0, so both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| src_in | input | 32 | Pool of source signals |
| out_int | output | 1 | Cell result for internal use |
| out_pin | output | 1 | Cell result for the pin |

## Verification
In the storage modes, a set condition and a reset condition can arrive in the same cycle. In the clocked modes, a gate-derived clock edge can also coincide with the asynchronous reset. Directed vectors drive set and reset together in the latch mode and drive J and K together with an edge. Random masks and sources then make these coincidences happen many times in every mode. In each case the bench's reference model gives reset priority and holds the prior state otherwise, and every output is compared against it.

// File: rtl/logic_cell_pkg.sv
package logic_cell_pkg;

    localparam int N_SRC        = 32;
    localparam int N_LINES      = 4;
    localparam int SEL_W        = $clog2(N_SRC);
    localparam int MASK_W       = 2 * N_LINES;
    localparam int MODE_W       = 3;
    localparam int CFG_W        = 32;
    localparam int ADDR_W       = 2;
    localparam int FIELD_STRIDE = 8;
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_INV_BIT  = 1;
    localparam int CTL_MODE_LSB = 2;
    localparam int CTL_GINV_LSB = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SEL  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd2;

    typedef enum logic [MODE_W-1:0] {
        MODE_ANDOR = 3'd0,
        MODE_ORXOR = 3'd1,
        MODE_AND4  = 3'd2,
        MODE_SRLAT = 3'd3,
        MODE_DFF   = 3'd4,
        MODE_JKFF  = 3'd5,
        MODE_DLAT  = 3'd6,
        MODE_NAND4 = 3'd7
    } mode_e;

    typedef struct packed {
        logic                              en;
        logic                              out_inv;
        mode_e                             mode;
        logic [N_LINES-1:0]                gate_inv;
        logic [N_LINES-1:0][SEL_W-1:0]     sel;
        logic [N_LINES-1:0][MASK_W-1:0]    mask;
    } cfg_t;

    typedef struct packed {
        logic q;
        logic clk_prev;
    } core_st_t;

endpackage

// File: rtl/logic_cell_cfg.sv
module logic_cell_cfg
    import logic_cell_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output cfg_t              cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                ADDR_CTL: begin
                    cfg_d.en       = wdata[CTL_EN_BIT];
                    cfg_d.out_inv  = wdata[CTL_INV_BIT];
                    cfg_d.mode     = mode_e'(wdata[CTL_MODE_LSB +: MODE_W]);
                    cfg_d.gate_inv = wdata[CTL_GINV_LSB +: N_LINES];
                end
                ADDR_SEL: begin
                    for (int k = 0; k < N_LINES; k++) begin
                        cfg_d.sel[k] = wdata[k*FIELD_STRIDE +: SEL_W];
                    end
                end
                ADDR_MASK: begin
                    for (int k = 0; k < N_LINES; k++) begin
                        cfg_d.mask[k] = wdata[k*FIELD_STRIDE +: MASK_W];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/logic_cell_gates.sv
module logic_cell_gates
    import logic_cell_pkg::*;
(
    input  logic [N_SRC-1:0]              src,
    input  logic [N_LINES-1:0][SEL_W-1:0] sel,
    input  logic [N_LINES-1:0][MASK_W-1:0] mask,
    input  logic [N_LINES-1:0]            gate_inv,
    output logic [N_LINES-1:0]            gate
);

    logic [N_LINES-1:0] line;

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        assign line[k] = src[sel[k]];
    end

    for (genvar k = 0; k < N_LINES; k++) begin : g_gate
        logic [N_LINES-1:0] true_terms;
        logic [N_LINES-1:0] inv_terms;
        assign true_terms = mask[k][N_LINES-1:0] & line;
        assign inv_terms  = mask[k][MASK_W-1:N_LINES] & ~line;
        assign gate[k]    = (|(true_terms | inv_terms)) ^ gate_inv[k];
    end

endmodule

// File: rtl/logic_cell_core.sv
module logic_cell_core
    import logic_cell_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               out_inv,
    input  mode_e              mode,
    input  logic [N_LINES-1:0] gate,
    output logic               result,
    output logic               state
);

    core_st_t st_d, st_q;
    logic     edge_ev;
    logic     core_val;
    logic     jk_j, jk_k;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = gate[0];
        edge_ev       = gate[0] & ~st_q.clk_prev;
        jk_j          = gate[1];
        jk_k          = gate[3];
        core_val      = st_q.q;

        case (mode)
            MODE_ANDOR: begin
                core_val = (gate[0] & gate[1]) | (gate[2] & gate[3]);
                st_d.q   = 1'b0;
            end
            MODE_ORXOR: begin
                core_val = (gate[0] | gate[1]) ^ (gate[2] | gate[3]);
                st_d.q   = 1'b0;
            end
            MODE_AND4: begin
                core_val = &gate;
                st_d.q   = 1'b0;
            end
            MODE_NAND4: begin
                core_val = ~(&gate);
                st_d.q   = 1'b0;
            end
            MODE_SRLAT: begin
                if (gate[2] | gate[3]) begin
                    st_d.q = 1'b0;
                end else if (gate[0] | gate[1]) begin
                    st_d.q = 1'b1;
                end
            end
            MODE_DFF: begin
                if (gate[2]) begin
                    st_d.q = 1'b0;
                end else if (gate[3]) begin
                    st_d.q = 1'b1;
                end else if (edge_ev) begin
                    st_d.q = gate[1];
                end
            end
            MODE_DLAT: begin
                if (gate[0]) begin
                    st_d.q = 1'b0;
                end else if (gate[3]) begin
                    st_d.q = 1'b1;
                end else if (gate[2]) begin
                    st_d.q = gate[1];
                end
            end
            MODE_JKFF: begin
                if (gate[2]) begin
                    st_d.q = 1'b0;
                end else if (edge_ev) begin
                    case ({jk_j, jk_k})
                        2'b10:   st_d.q = 1'b1;
                        2'b01:   st_d.q = 1'b0;
                        2'b11:   st_d.q = ~st_q.q;
                        default: st_d.q = st_q.q;
                    endcase
                end
            end
            default: ;
        endcase

        if (!en) begin
            st_d.q = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = en & (core_val ^ out_inv);
    assign state  = st_q.q;

endmodule

// File: rtl/logic_cell.sv
module logic_cell
    import logic_cell_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [N_SRC-1:0]  src_in,
    output logic              out_int,
    output logic              out_pin
);

    cfg_t               cfg_w;
    logic [N_LINES-1:0] gate_w;
    logic               result_w;
    logic               state_w;

    logic_cell_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg_w)
    );

    logic_cell_gates u_gates (
        .src      (src_in),
        .sel      (cfg_w.sel),
        .mask     (cfg_w.mask),
        .gate_inv (cfg_w.gate_inv),
        .gate     (gate_w)
    );

    logic_cell_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_w.en),
        .out_inv (cfg_w.out_inv),
        .mode    (cfg_w.mode),
        .gate    (gate_w),
        .result  (result_w),
        .state   (state_w)
    );

    assign out_int = result_w;
    assign out_pin = result_w;

endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk
    import logic_cell_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic              en,
    input logic [MODE_W-1:0] mode,
    input logic [N_LINES-1:0] gate,
    input logic              state,
    input logic              out_int,
    input logic              out_pin
);

    a_r10_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!out_int && !out_pin));

    a_r10_state_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !state);

    a_r11_outputs_agree: assert property (@(posedge clk) disable iff (!rst_n)
        out_int == out_pin);

    a_r1_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_CTL) |=> (en == $past(cfg_wdata[CTL_EN_BIT])));

    a_r6_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_SRLAT && (gate[2] || gate[3])) |=> !state);

    a_r8_latch_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_DLAT && gate[0]) |=> !state);

    a_r9_jk_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_JKFF && gate[2]) |=> !state);

endmodule

bind logic_cell logic_cell_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .en        (cfg_w.en),
    .mode      (cfg_w.mode),
    .gate      (gate_w),
    .state     (state_w),
    .out_int   (out_int),
    .out_pin   (out_pin)
);

// File: tb/logic_cell_tb.sv
`timescale 1ns/1ps
module logic_cell_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] src_in = '0;
    logic        out_int, out_pin;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    logic [31:0] m_ctl = '0, m_sel = '0, m_msk = '0;
    logic        m_q = 1'b0, m_prev = 1'b0;

    always #2.5 clk = ~clk;

    logic_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .src_in(src_in), .out_int(out_int), .out_pin(out_pin)
    );

    function automatic logic [3:0] model_gates(input logic [31:0] s);
        logic [3:0] line, g;
        logic [7:0] mb;
        for (int k = 0; k < 4; k++) line[k] = s[m_sel[8*k +: 5]];
        for (int k = 0; k < 4; k++) begin
            mb   = m_msk[8*k +: 8];
            g[k] = (|((mb[3:0] & line) | (mb[7:4] & ~line))) ^ m_ctl[8+k];
        end
        return g;
    endfunction

    function automatic logic model_out(input logic [3:0] g);
        logic v;
        case (m_ctl[4:2])
            3'd0: v = (g[0] & g[1]) | (g[2] & g[3]);
            3'd1: v = (g[0] | g[1]) ^ (g[2] | g[3]);
            3'd2: v = &g;
            3'd7: v = ~(&g);
            default: v = m_q;
        endcase
        return m_ctl[0] & (v ^ m_ctl[1]);
    endfunction

    function automatic logic model_next(input logic [3:0] g);
        logic ev;
        ev = g[0] & ~m_prev;
        if (!m_ctl[0]) return 1'b0;
        case (m_ctl[4:2])
            3'd3: return (g[2] | g[3]) ? 1'b0 : ((g[0] | g[1]) ? 1'b1 : m_q);
            3'd4: return g[2] ? 1'b0 : (g[3] ? 1'b1 : (ev ? g[1] : m_q));
            3'd6: return g[0] ? 1'b0 : (g[3] ? 1'b1 : (g[2] ? g[1] : m_q));
            3'd5: begin
                if (g[2]) return 1'b0;
                if (!ev) return m_q;
                case ({g[1], g[3]})
                    2'b10: return 1'b1;
                    2'b01: return 1'b0;
                    2'b11: return ~m_q;
                    default: return m_q;
                endcase
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic string auto_tag();
        if (!m_ctl[0]) return "R10";
        case (m_ctl[4:2])
            3'd3: return "R6";
            3'd4: return "R7";
            3'd6: return "R8";
            3'd5: return "R9";
            default: return m_ctl[1] ? "R5" : "R4";
        endcase
    endfunction

    task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                        input logic [31:0] s, input string tag);
        logic [3:0] g;
        logic       exp, nq;
        string      t;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d; src_in = s;
        #1;
        g   = model_gates(s);
        exp = model_out(g);
        t   = (tag == "") ? auto_tag() : tag;
        n_vec++;
        if (out_int !== exp) begin
            n_bad++;
            $display("FAIL %s mode=%0d out_int=%b expected=%b", t, m_ctl[4:2], out_int, exp);
        end
        n_vec++;
        if (out_pin !== out_int) begin  // R11
            n_bad++;
            $display("FAIL R11 out_pin=%b expected=%b", out_pin, out_int);
        end
        nq = model_next(g);
        @(posedge clk);
        m_q    = nq;
        m_prev = g[0];
        if (we) begin
            case (a)
                2'd0: m_ctl = d;
                2'd1: m_sel = d;
                2'd2: m_msk = d;
                default: ;
            endcase
        end
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (out_int !== 1'b0 || out_pin !== 1'b0) begin  // R12 during reset
            n_bad++;
            $display("FAIL R12 out=%b%b expected=00", out_int, out_pin);
        end
        rst_n = 1'b1;
        step(1'b0, 2'd0, 32'h0, 32'hFFFF_FFFF, "R12");

        // identity routing: line j <- src j, gate k <- line k true
        step(1'b1, 2'd1, 32'h0302_0100, 32'h0, "R1");
        step(1'b1, 2'd2, 32'h0804_0201, 32'h0, "R1");
        // R6 set-reset latch: simultaneous set and reset, then set, hold, reset
        step(1'b1, 2'd0, 32'h0000_000D, 32'h0, "");
        step(1'b0, 2'd0, 32'h0, 32'h5, "R6");
        step(1'b0, 2'd0, 32'h0, 32'h1, "R6");
        step(1'b0, 2'd0, 32'h0, 32'h0, "R6");
        step(1'b0, 2'd0, 32'h0, 32'h0, "R6");
        step(1'b0, 2'd0, 32'h0, 32'h9, "R6");
        step(1'b0, 2'd0, 32'h0, 32'h0, "R6");
        // R9 J-K toggle with J=K=1
        step(1'b1, 2'd0, 32'h0000_0015, 32'hA, "R9");
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 2'd0, 32'h0, 32'hB, "R9");
            step(1'b0, 2'd0, 32'h0, 32'hA, "R9");
        end
        // R7 clocked D: edge captures D, reset beats set
        step(1'b1, 2'd0, 32'h0000_0011, 32'h0, "R7");
        step(1'b0, 2'd0, 32'h0, 32'h3, "R7");
        step(1'b0, 2'd0, 32'h0, 32'h1, "R7");
        step(1'b0, 2'd0, 32'h0, 32'hC, "R7");
        step(1'b0, 2'd0, 32'h0, 32'h0, "R7");
        // R3 empty masks with all gate inverts: every gate is 1, AND gives 1
        step(1'b1, 2'd2, 32'h0, 32'h0, "R3");
        step(1'b1, 2'd0, 32'h0000_0F09, 32'h1234_5678, "R3");
        step(1'b0, 2'd0, 32'h0, 32'hFFFF_FFFF, "R3");
        // R1 address 3 write is ignored
        step(1'b1, 2'd3, 32'h0, 32'h0, "R1");
        step(1'b0, 2'd0, 32'h0, 32'h0, "R1");
        // R2 high select values
        step(1'b1, 2'd2, 32'h0804_0201, 32'h0, "R2");
        step(1'b1, 2'd1, 32'h1C1D_1E1F, 32'h0, "R2");
        step(1'b1, 2'd0, 32'h0000_0009, 32'hF000_0000, "R2");
        step(1'b0, 2'd0, 32'h0, 32'hF000_0000, "R2");
        step(1'b0, 2'd0, 32'h0, 32'h7FFF_FFFF, "R2");
        // R5 inverted AND-OR
        step(1'b1, 2'd0, 32'h0000_0003, 32'h3000_0000, "R5");
        step(1'b0, 2'd0, 32'h0, 32'h3000_0000, "R5");
        step(1'b0, 2'd0, 32'h0, 32'h1000_0000, "R5");
        // R10 disabled
        step(1'b1, 2'd0, 32'h0000_0002, 32'hFFFF_FFFF, "R10");
        step(1'b0, 2'd0, 32'h0, 32'hFFFF_FFFF, "R10");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) begin
                logic [31:0] w;
                w = $urandom;
                if (r[5:4] == 2'd0) w[0] = (r[9:6] != 4'd0);
                step(1'b1, r[5:4], w, $urandom, "");
            end else begin
                step(1'b0, 2'd0, 32'h0, $urandom, "");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule